// File: doc/BRIEF.md
# Time Base with Programmable and Fixed Interval Timers

This block keeps a free-running 64-bit time base that advances by one on every cycle in which the tick enable is high. Two timers are paced by that same tick. The programmable interval timer is a 32-bit down-counter. Software loads it and it counts down once per tick. On reaching zero it either halts there or, when auto-reload is on, starts again from the last value software wrote. The fixed interval timer watches one of four time-base bits and flags an event whenever a time-base increment carries that bit from 0 to 1.

Both timers report through a two-bit status register. A status bit is cleared by writing 1 to it. Each interrupt output is its status bit gated by an enable bit in the control register. Software reaches the time base, the down-counter, the control register and the status register through a simple single-cycle register port. Writes take effect at the next clock edge, and the read data is combinational from the address.

Register map (3-bit address): 0 = time base bits 31:0, 1 = time base bits 63:32, 2 = down-counter, 3 = control, 4 = status. Any other address reads as zero.

Top module: `interval_timer_unit`

## Requirements
- R1: After reset the time base is zero. It increases by exactly 1 on each clock edge where `tick_en` is high. A write to address 0 or 1 loads that 32-bit half, and on that edge the whole time base does not increment, even if `tick_en` is high.
- R2: A write to address 2 loads the down-counter. A read of address 2 returns the current count. The count falls by 1 on each ticked edge while it is nonzero.
- R3: With auto-reload off (control bit 2 = 0), a tick that takes the count from 1 to 0 sets status bit 0. The count then stays at 0 however many ticks follow.
- R4: With auto-reload on (control bit 2 = 1), the tick that would take the count from 1 to 0 instead loads the last value written to address 2. It also sets status bit 0, and counting continues.
- R5: Writing 0 to address 2 leaves the timer idle, and status bit 0 is not set by any later tick. A write while counting replaces both the current count and the saved reload value.
- R6: Control bits 4:3 pick the fixed-interval tap: 00 selects time-base bit 9, 01 bit 13, 10 bit 17 and 11 bit 21. Status bit 1 is set when an increment changes the selected bit from 0 to 1. A software write to the time base never sets it.
- R7: Writing to address 4 clears each status bit whose write-data bit is 1. Bits written as 0 are unchanged.
- R8: `pit_irq` equals status bit 0 AND control bit 0. `fit_irq` equals status bit 1 AND control bit 1.
- R9: If a timer event and a write-one-to-clear of the same status bit fall on the same edge, the bit ends up set.
- R10: After reset, every register reads zero and both interrupts are low. Control reads back its five bits at positions 4:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Time-base advance enable, one increment per cycle high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for both read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pit_irq | output | 1 | Down-counter interrupt |
| fit_irq | output | 1 | Fixed-interval interrupt |

## Verification
Two kinds of collision can land on one clock edge. A timer event can meet a software write-one-to-clear of the same status bit. A tick can also meet a software write to the very register it would advance. The bench provokes the first by loading the down-counter to 1 with its status already set, or by placing the time base one below a tap rise. It then raises `tick_en` and the status clear in the same cycle and expects the bit still set afterwards. For the second, it writes the time base or the down-counter in a ticked cycle and expects the written value back, with no extra decrement or increment.

// File: rtl/timer_pkg.sv
package timer_pkg;

    localparam int DATA_W   = 32;
    localparam int TB_W     = 2 * DATA_W;
    localparam int PIT_W    = 32;
    localparam int ADDR_W   = 3;
    localparam int FIT_N    = 4;
    localparam int FIT_BASE = 9;
    localparam int FIT_STEP = 4;
    localparam int SEL_W    = $clog2(FIT_N);

    localparam logic [ADDR_W-1:0] A_TB_LO  = 3'd0;
    localparam logic [ADDR_W-1:0] A_TB_HI  = 3'd1;
    localparam logic [ADDR_W-1:0] A_PIT    = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd3;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd4;

    // Control register layout, LSB last in the declaration.
    typedef struct packed {
        logic [SEL_W-1:0] fit_sel;
        logic             auto_rl;
        logic             fit_ie;
        logic             pit_ie;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic fit;
        logic pit;
    } stat_t;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wreq_t;

    function automatic int fit_tap(input int idx);
        return FIT_BASE + idx * FIT_STEP;
    endfunction

    function automatic logic hits(input wreq_t w, input logic [ADDR_W-1:0] a);
        return w.we && (w.addr == a);
    endfunction

endpackage

// File: rtl/tb_counter.sv
module tb_counter
    import timer_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            tick_en,
    input  wreq_t           wreq,
    output logic [TB_W-1:0] tb_q,
    output logic            inc_ok
);
    localparam int HALF = TB_W / 2;

    logic wr_lo, wr_hi;

    always_comb begin
        wr_lo  = hits(wreq, A_TB_LO);
        wr_hi  = hits(wreq, A_TB_HI);
        inc_ok = tick_en && !wr_lo && !wr_hi;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tb_q <= '0;
        end else if (wr_lo) begin
            tb_q[HALF-1:0] <= wreq.data[HALF-1:0];
        end else if (wr_hi) begin
            tb_q[TB_W-1:HALF] <= wreq.data[HALF-1:0];
        end else if (inc_ok) begin
            tb_q <= tb_q + TB_W'(1);
        end
    end
endmodule

// File: rtl/pit_counter.sv
module pit_counter
    import timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             auto_rl,
    input  wreq_t            wreq,
    output logic [PIT_W-1:0] count_q,
    output logic             evt
);
    logic [PIT_W-1:0] reload_q;
    logic             load;
    logic             step;
    logic             last;

    always_comb begin
        load = hits(wreq, A_PIT);
        step = tick_en && !load && (count_q != '0);
        last = (count_q == PIT_W'(1));
        evt  = step && last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            reload_q <= '0;
        end else if (load) begin
            count_q  <= wreq.data[PIT_W-1:0];
            reload_q <= wreq.data[PIT_W-1:0];
        end else if (step) begin
            if (last && auto_rl) begin
                count_q <= reload_q;
            end else begin
                count_q <= count_q - PIT_W'(1);
            end
        end
    end
endmodule

// File: rtl/fit_detect.sv
module fit_detect
    import timer_pkg::*;
(
    input  logic [TB_W-1:0]  tb_q,
    input  logic             inc_ok,
    input  logic [SEL_W-1:0] sel,
    output logic             evt
);
    logic [FIT_N-1:0] rise;

    // An increment turns bit TAP from 0 to 1 exactly when all lower bits are 1.
    for (genvar i = 0; i < FIT_N; i++) begin : g_tap
        localparam int TAP = fit_tap(i);
        assign rise[i] = (&tb_q[TAP-1:0]) & ~tb_q[TAP];
    end

    assign evt = inc_ok && rise[sel];
endmodule

// File: rtl/timer_regs.sv
module timer_regs
    import timer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  wreq_t wreq,
    input  logic  pit_evt,
    input  logic  fit_evt,
    output ctrl_t ctrl_q,
    output stat_t stat_q
);
    stat_t clr;
    stat_t set;

    always_comb begin
        clr = '0;
        if (hits(wreq, A_STATUS)) begin
            clr = stat_t'(wreq.data[$bits(stat_t)-1:0]);
        end
        set.pit = pit_evt;
        set.fit = fit_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            stat_q <= '0;
        end else begin
            if (hits(wreq, A_CTRL)) begin
                ctrl_q <= ctrl_t'(wreq.data[CTRL_W-1:0]);
            end
            // A new event overrides a clear on the same edge.
            stat_q <= (stat_q & ~clr) | set;
        end
    end
endmodule

// File: rtl/interval_timer_unit.sv
module interval_timer_unit
    import timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              pit_irq,
    output logic              fit_irq
);
    wreq_t            wreq;
    logic [TB_W-1:0]  tb_q;
    logic             inc_ok;
    logic [PIT_W-1:0] pit_count;
    logic             pit_evt;
    logic             fit_evt;
    ctrl_t            ctrl_q;
    stat_t            stat_q;

    assign wreq.we   = wr_en;
    assign wreq.addr = addr;
    assign wreq.data = wdata;

    tb_counter u_tb (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .wreq    (wreq),
        .tb_q    (tb_q),
        .inc_ok  (inc_ok)
    );

    pit_counter u_pit (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .auto_rl (ctrl_q.auto_rl),
        .wreq    (wreq),
        .count_q (pit_count),
        .evt     (pit_evt)
    );

    fit_detect u_fit (
        .tb_q    (tb_q),
        .inc_ok  (inc_ok),
        .sel     (ctrl_q.fit_sel),
        .evt     (fit_evt)
    );

    timer_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wreq    (wreq),
        .pit_evt (pit_evt),
        .fit_evt (fit_evt),
        .ctrl_q  (ctrl_q),
        .stat_q  (stat_q)
    );

    always_comb begin
        unique case (addr)
            A_TB_LO:  rdata = tb_q[DATA_W-1:0];
            A_TB_HI:  rdata = tb_q[TB_W-1:DATA_W];
            A_PIT:    rdata = DATA_W'(pit_count);
            A_CTRL:   rdata = DATA_W'(ctrl_q);
            A_STATUS: rdata = DATA_W'(stat_q);
            default:  rdata = '0;
        endcase
    end

    assign pit_irq = stat_q.pit & ctrl_q.pit_ie;
    assign fit_irq = stat_q.fit & ctrl_q.fit_ie;
endmodule

// File: rtl/timer_unit_checker.sv
module timer_unit_checker
    import timer_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [TB_W-1:0]   tb_q,
    input logic [PIT_W-1:0]  pit_count,
    input logic              pit_evt,
    input logic              fit_evt,
    input logic [1:0]        stat_bits,
    input logic              auto_rl
);
    logic wr_tb, wr_pit, wr_st;
    assign wr_tb  = wr_en && (addr == A_TB_LO || addr == A_TB_HI);
    assign wr_pit = wr_en && (addr == A_PIT);
    assign wr_st  = wr_en && (addr == A_STATUS);

    assert_tb_step_R1: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !wr_tb) |=> tb_q == $past(tb_q) + TB_W'(1));

    assert_pit_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !wr_pit && pit_count > PIT_W'(1)) |=> pit_count == $past(pit_count) - PIT_W'(1));

    assert_pit_halt_R3: assert property (@(posedge clk) disable iff (rst)
        (!auto_rl && pit_count == '0 && !wr_pit) |=> pit_count == '0);

    assert_pit_event_R9: assert property (@(posedge clk) disable iff (rst)
        pit_evt |=> stat_bits[0]);

    assert_fit_event_R9: assert property (@(posedge clk) disable iff (rst)
        fit_evt |=> stat_bits[1]);

    assert_pit_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_st && wdata[0] && !pit_evt) |=> !stat_bits[0]);

    assert_fit_no_write_rise_R6: assert property (@(posedge clk) disable iff (rst)
        wr_tb |-> !fit_evt);
endmodule

bind interval_timer_unit timer_unit_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .tb_q      (tb_q),
    .pit_count (pit_count),
    .pit_evt   (pit_evt),
    .fit_evt   (fit_evt),
    .stat_bits (stat_q),
    .auto_rl   (ctrl_q.auto_rl)
);

// File: tb/test_interval_timer_unit.sv
module test_interval_timer_unit;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pit_irq, fit_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    interval_timer_unit i_interval_timer_unit (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .pit_irq(pit_irq), .fit_irq(fit_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    // Tick and write on the very same edge.
    task automatic tick_with_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        tick_en = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            check("R10 reset register", v, 32'h0);
        end
        check("R10 reset pit_irq", {31'b0, pit_irq}, 0);
        check("R10 reset fit_irq", {31'b0, fit_irq}, 0);
    endtask

    task automatic t_timebase();
        logic [31:0] v;
        wr(3'd0, 32'h10);
        ticks(5);
        rd(3'd0, v); check("R1 increment", v, 32'h15);
        wr(3'd1, 32'h1);
        rd(3'd1, v); check("R1 high half write", v, 32'h1);
        rd(3'd0, v); check("R1 low half held", v, 32'h15);
        tick_with_write(3'd0, 32'h100);
        rd(3'd0, v); check("R1 write beats tick", v, 32'h100);
    endtask

    task automatic t_pit_oneshot();
        logic [31:0] v;
        wr(3'd3, 32'h1);
        rd(3'd3, v); check("R10 control readback", v, 32'h1);
        wr(3'd2, 32'd5);
        ticks(3);
        rd(3'd2, v); check("R2 count down", v, 32'd2);
        rd(3'd4, v); check("R3 no status early", v, 32'h0);
        ticks(2);
        rd(3'd2, v); check("R3 reaches zero", v, 32'd0);
        rd(3'd4, v); check("R3 status set", v, 32'h1);
        check("R8 pit_irq on", {31'b0, pit_irq}, 1);
        ticks(3);
        rd(3'd2, v); check("R3 stays zero", v, 32'd0);
        wr(3'd4, 32'h2);
        rd(3'd4, v); check("R7 zero bit kept", v, 32'h1);
        wr(3'd4, 32'h1);
        rd(3'd4, v); check("R7 clear", v, 32'h0);
        check("R8 pit_irq off", {31'b0, pit_irq}, 0);
    endtask

    task automatic t_pit_reload();
        logic [31:0] v;
        wr(3'd3, 32'h5);
        wr(3'd2, 32'd4);
        ticks(4);
        rd(3'd2, v); check("R4 reloaded", v, 32'd4);
        rd(3'd4, v); check("R4 status set", v, 32'h1);
        ticks(1);
        rd(3'd2, v); check("R4 continues", v, 32'd3);
        wr(3'd4, 32'h1);
        wr(3'd2, 32'd10);
        ticks(2);
        wr(3'd2, 32'd3);
        ticks(3);
        rd(3'd2, v); check("R5 new reload value", v, 32'd3);
        rd(3'd4, v); check("R5 rewrite counted", v, 32'h1);
        wr(3'd4, 32'h1);
        wr(3'd3, 32'h1);
        wr(3'd2, 32'd0);
        ticks(10);
        rd(3'd2, v); check("R5 idle at zero", v, 32'd0);
        rd(3'd4, v); check("R5 no status idle", v, 32'h0);
        check("R8 idle irq low", {31'b0, pit_irq}, 0);
        wr(3'd2, 32'd6);
        tick_with_write(3'd2, 32'd9);
        rd(3'd2, v); check("R2 write beats tick", v, 32'd9);
        wr(3'd2, 32'd0);
    endtask

    task automatic t_fit();
        logic [31:0] v;
        wr(3'd3, {27'b0, 2'b00, 3'b010});
        wr(3'd0, 32'h1FE);
        wr(3'd4, 32'h3);
        ticks(1);
        rd(3'd4, v); check("R6 no rise yet", v, 32'h0);
        ticks(1);
        rd(3'd4, v); check("R6 tap bit 9", v, 32'h2);
        check("R8 fit_irq on", {31'b0, fit_irq}, 1);
        wr(3'd3, {27'b0, 2'b01, 3'b000});
        check("R8 fit_irq masked", {31'b0, fit_irq}, 0);
        wr(3'd4, 32'h2);
        wr(3'd0, 32'h1FFE);
        ticks(2);
        rd(3'd4, v); check("R6 tap bit 13", v, 32'h2);
        wr(3'd3, {27'b0, 2'b10, 3'b000});
        wr(3'd4, 32'h2);
        wr(3'd0, 32'h1FFFF);
        ticks(1);
        rd(3'd4, v); check("R6 tap bit 17", v, 32'h2);
        wr(3'd3, {27'b0, 2'b11, 3'b000});
        wr(3'd4, 32'h2);
        wr(3'd0, 32'h1FFFF);
        ticks(1);
        rd(3'd4, v); check("R6 bit 17 ignored on tap 21", v, 32'h0);
        wr(3'd0, 32'h1FFFFF);
        ticks(1);
        rd(3'd4, v); check("R6 tap bit 21", v, 32'h2);
        wr(3'd3, {27'b0, 2'b00, 3'b010});
        wr(3'd4, 32'h2);
        wr(3'd0, 32'h0);
        wr(3'd0, 32'h200);
        rd(3'd4, v); check("R6 write rise ignored", v, 32'h0);
        check("R6 fit_irq low after write", {31'b0, fit_irq}, 0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        wr(3'd3, 32'h1);
        wr(3'd2, 32'd1);
        ticks(1);
        rd(3'd4, v); check("R9 setup pit status", v, 32'h1);
        wr(3'd2, 32'd1);
        tick_with_write(3'd4, 32'h1);
        rd(3'd4, v); check("R9 pit event beats clear", v, 32'h1);
        wr(3'd4, 32'h1);
        rd(3'd4, v); check("R7 pit clear after", v, 32'h0);
        wr(3'd0, 32'h1FF);
        tick_with_write(3'd4, 32'h2);
        rd(3'd4, v); check("R9 fit event beats clear", v, 32'h2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_timebase();
        t_pit_oneshot();
        t_pit_reload();
        t_fit();
        t_collide();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule